// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Adapter

This block translates a CPU's active-low bus strobes into the separate read, write and interrupt-acknowledge strobes that a peripheral family expects. Ordinary memory and I/O cycles pass through. The CPU read and write strobes reach the peripheral side, and the system wait request reaches the CPU. An acknowledge cycle is recognised early. At the first clock edge where the opcode-fetch strobe is low and the memory request is high, the block asserts the acknowledge strobe.

A delay chain of one flop per clock then holds the peripheral read strobe back for a programmable number of clocks. This gives the interrupt priority chain time to settle. While that delay runs, the CPU is held in wait states. The CPU and the peripheral share one clock, so each extra chain stage adds exactly one clock.

A low system reset drives the peripheral read and write strobes low together, which is the peripheral's reset condition.

Top module: `iack_bus_adapter`

## Requirements
- R1: While the opcode-fetch strobe (m1) is high, per_intack_n stays high, per_rd_n equals cpu_rd_n and cpu_wait_n equals sys_wait_n.
- R2: In an opcode fetch, m1 is low and the memory request is low at the first clock edge. per_intack_n then stays high for the whole cycle, and per_rd_n follows cpu_rd_n.
- R3: At a rising edge where m1 is low and the memory request is high, per_intack_n goes low right after that edge. It stays low while m1 stays low and every later edge still sees the memory request high.
- R4: per_rd_n is forced low exactly TAP_DLY rising edges after per_intack_n went low (default 3), whatever the level of cpu_rd_n.
- R5: cpu_wait_n is low from the cycle per_intack_n goes low up to, but not including, the cycle the delayed read asserts.
- R6: When m1 returns high, per_intack_n, the delayed read and the acknowledge wait are released in that same cycle. The next cycle starts with a cleared chain.
- R7: While rst_n is low, per_rd_n and per_wr_n are both low and per_intack_n is high. Reset is sampled synchronously for the chain.
- R8: Outside reset, per_wr_n equals cpu_wr_n in every cycle type.
- R9: A low sys_wait_n forces cpu_wait_n low in every cycle type, including during and after the acknowledge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared CPU and peripheral clock |
| rst_n | input | 1 | System reset, active low |
| cpu_m1_n | input | 1 | Opcode-fetch / acknowledge cycle strobe, active low |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_iorq_n | input | 1 | I/O request, active low (observed only) |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| sys_wait_n | input | 1 | Wait request from other system logic, active low |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| per_intack_n | output | 1 | Peripheral interrupt acknowledge, active low |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
The bench runs memory-read, I/O-write and opcode-fetch sequences. These show that an active m1 alone does not start an acknowledge, because the fetch's low memory request keeps it out.

Acknowledge cycles are then swept over every hold length from 1 to 8 clocks. Each length is crossed with a system wait pulse at every position and with the CPU read strobe held high or low. This separates a read tap taken one stage early or late from a correct one. It also shows whether the wait release lines up with the delayed read and whether the release at the end of m1 is immediate.

A reset applied in the middle of an acknowledge shows the forced read-and-write condition and that the chain is cleared.

// File: rtl/iack_pkg.sv
// Package: shared strobe bundle and helpers for the acknowledge adapter.
// Assumes all strobes are active low, with 1 meaning inactive.
package iack_pkg;

    // Bundle of strobes the adapter drives.
    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic intack_n;
        logic wait_n;
    } iack_strobes_t;

    // Idle value of the bundle: every strobe inactive.
    localparam iack_strobes_t STROBES_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, intack_n: 1'b1, wait_n: 1'b1};

    // Number of flops needed so the read tap sits tap_dly stages past the first.
    function automatic int chain_len(input int tap_dly);
        return tap_dly + 1;
    endfunction

endpackage

// File: rtl/iack_delay_chain.sv
// Delay chain: a shift register clocked on every rising edge.
// Stage 0 takes din; stage i takes stage i-1.
// A high clr (m1 inactive) or a low rst_n empties the whole chain on the next edge.
// Assumes DEPTH >= 2.
module iack_delay_chain #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             din,
    output logic [DEPTH-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            // Purpose: hold one chain stage, cleared by reset or clr.
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) q[gi] <= 1'b0;
                    else               q[gi] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) q[gi] <= 1'b0;
                    else               q[gi] <= q[gi-1];
                end
            end
        end
    endgenerate

    // R6: a cycle with m1 inactive leaves the chain empty afterwards
    a_r6_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (q == '0));

    // R3: a set bit deeper in the chain implies the head was set one edge earlier
    a_r3_ordered_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q[1]) |=> (clr || q[1] || !q[0] || 1'b1) && ($past(q[0]) || !q[1] || $past(clr)));

endmodule

// File: rtl/iack_strobe_gate.sv
// Strobe gate: merges the CPU strobes with the delay-chain taps.
// The acknowledge taps act only while m1 is low and reset is released,
// so the outputs release in the same cycle m1 rises.
// Reset forces read and write low together.
module iack_strobe_gate
    import iack_pkg::*;
(
    input  logic          rst_n,
    input  logic          cpu_m1_n,
    input  logic          cpu_rd_n,
    input  logic          cpu_wr_n,
    input  logic          sys_wait_n,
    input  logic          tap_seen,
    input  logic          tap_ready,
    output iack_strobes_t strobes
);

    logic ack_live;
    logic ack_seen;
    logic ack_ready;

    // Purpose: qualify the chain taps with an open acknowledge cycle.
    always_comb begin
        ack_live  = rst_n & ~cpu_m1_n;
        ack_seen  = ack_live & tap_seen;
        ack_ready = ack_live & tap_ready;
    end

    // Purpose: form the four output strobes from the CPU strobes and the taps.
    always_comb begin
        strobes          = STROBES_IDLE;
        strobes.intack_n = ~ack_seen;
        strobes.rd_n     = rst_n ? (cpu_rd_n & ~ack_ready) : 1'b0;
        strobes.wr_n     = rst_n ? cpu_wr_n : 1'b0;
        strobes.wait_n   = sys_wait_n & ~(ack_seen & ~ack_ready);
    end

endmodule

// File: rtl/iack_bus_adapter.sv
// Top level: early acknowledge detection and delayed peripheral read.
// The chain shifts in "memory request inactive" while m1 is low.
// Stage 0 drives the acknowledge strobe; stage TAP_DLY drives the delayed read
// and ends the wait.
// Assumes one shared clock, a synchronous active-low reset, and TAP_DLY >= 1.
module iack_bus_adapter
    import iack_pkg::*;
#(
    parameter int TAP_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_m1_n,
    input  logic cpu_mreq_n,
    input  logic cpu_iorq_n,
    input  logic cpu_rd_n,
    input  logic cpu_wr_n,
    input  logic sys_wait_n,
    output logic per_rd_n,
    output logic per_wr_n,
    output logic per_intack_n,
    output logic cpu_wait_n
);

    localparam int CHAIN_LEN = chain_len(TAP_DLY);
    localparam int CNT_W     = $clog2(TAP_DLY + 2) + 1;

    logic [CHAIN_LEN-1:0] chain_q;
    iack_strobes_t        strobes;

    iack_delay_chain #(.DEPTH(CHAIN_LEN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cpu_m1_n),
        .din   (cpu_mreq_n),
        .q     (chain_q)
    );

    iack_strobe_gate u_gate (
        .rst_n      (rst_n),
        .cpu_m1_n   (cpu_m1_n),
        .cpu_rd_n   (cpu_rd_n),
        .cpu_wr_n   (cpu_wr_n),
        .sys_wait_n (sys_wait_n),
        .tap_seen   (chain_q[0]),
        .tap_ready  (chain_q[TAP_DLY]),
        .strobes    (strobes)
    );

    // Purpose: unpack the strobe bundle onto the ports.
    always_comb begin
        per_rd_n     = strobes.rd_n;
        per_wr_n     = strobes.wr_n;
        per_intack_n = strobes.intack_n;
        cpu_wait_n   = strobes.wait_n;
    end

    // Checker counter: edges since the acknowledge strobe went low (saturating).
    logic [CNT_W-1:0] ack_age;
    always_ff @(posedge clk) begin
        if (!rst_n || per_intack_n) ack_age <= '0;
        else if (ack_age <= CNT_W'(TAP_DLY)) ack_age <= ack_age + 1'b1;
    end

    // R7: reset forces read and write low together and keeps the acknowledge idle
    a_r7_reset_strobes: assert property (@(posedge clk)
        !rst_n |-> (!per_rd_n && !per_wr_n && per_intack_n));

    // R2: a fetch (memory request low) never starts an acknowledge
    a_r2_fetch_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_m1_n && !cpu_mreq_n && per_intack_n) |=> per_intack_n);

    // R3: the acknowledge is already visible when the I/O request appears
    a_r3_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_m1_n && !cpu_iorq_n && $past(!cpu_m1_n && cpu_mreq_n && rst_n)) |-> !per_intack_n);

    // R4: the read is held back until TAP_DLY edges after the acknowledge
    a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_intack_n && cpu_rd_n && ack_age < CNT_W'(TAP_DLY)) |-> per_rd_n);

    // R4: the read is asserted once the delay has elapsed
    a_r4_read_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_intack_n && ack_age >= CNT_W'(TAP_DLY)) |-> !per_rd_n);

    // R5: the CPU is released by the acknowledge path only when the read is active
    a_r5_wait_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_intack_n && cpu_wait_n) |-> !per_rd_n);

    // R6: a rising m1 releases the acknowledge in the same cycle
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_m1_n) |-> (per_intack_n && per_rd_n == cpu_rd_n && cpu_wait_n == sys_wait_n));

    // R9: an external wait request always reaches the CPU
    a_r9_wait_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_wait_n |-> !cpu_wait_n);

endmodule

// File: tb/iack_bus_adapter_tb.sv
// Bench: drives CPU cycle patterns and checks the outputs against a run-length model.
module iack_bus_adapter_tb;

    localparam int TAP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, swait_n = 1'b1;
    logic per_rd_n, per_wr_n, per_intack_n, cpu_wait_n;

    int checks = 0;
    int errors = 0;
    int run = 0;

    always #10 clk = ~clk;

    iack_bus_adapter #(.TAP_DLY(TAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_m1_n(m1_n), .cpu_mreq_n(mreq_n),
        .cpu_iorq_n(iorq_n), .cpu_rd_n(rd_n), .cpu_wr_n(wr_n), .sys_wait_n(swait_n),
        .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .per_intack_n(per_intack_n),
        .cpu_wait_n(cpu_wait_n)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive after the falling edge, check just before the rising edge,
    // then update the run-length model with the values sampled at that edge.
    task automatic step(input string tag, input logic rs, input logic m1, input logic mq,
                        input logic io, input logic rd, input logic wr, input logic wt);
        logic seen, ready;
        @(negedge clk);
        rst_n = rs; m1_n = m1; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr; swait_n = wt;
        #8;
        seen  = rs && !m1 && run >= 1;
        ready = rs && !m1 && run >= TAP + 1;
        chk(tag, "per_intack_n", per_intack_n, !seen);
        chk(tag, "per_rd_n", per_rd_n, rs ? (rd && !ready) : 1'b0);
        chk(tag, "per_wr_n", per_wr_n, rs ? wr : 1'b0);
        chk(tag, "cpu_wait_n", cpu_wait_n, wt && !(seen && !ready));
        @(posedge clk);
        if (!rs || m1 || !mq) run = 0;
        else if (run < 100) run = run + 1;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R7: reset state with CPU strobes idle
        for (int i = 0; i < 3; i++) step("R7", 0, 1, 1, 1, 1, 1, 1);
        step("R1", 1, 1, 1, 1, 1, 1, 1);
        // R1: memory read cycle
        step("R1", 1, 1, 1, 1, 1, 1, 1);
        step("R1", 1, 1, 0, 1, 0, 1, 1);
        step("R1", 1, 1, 0, 1, 0, 1, 0);
        step("R1", 1, 1, 1, 1, 1, 1, 1);
        // R8: I/O write cycle
        step("R8", 1, 1, 1, 0, 1, 0, 1);
        step("R8", 1, 1, 1, 0, 1, 0, 0);
        step("R8", 1, 1, 1, 1, 1, 1, 1);
        // R2: opcode fetch, with refresh afterwards
        for (int w = 0; w < 2; w++) begin
            step("R2", 1, 0, 0, 1, 0, 1, 1);
            step("R2", 1, 0, 0, 1, 0, 1, w[0] ? 1'b0 : 1'b1);
            step("R2", 1, 1, 0, 1, 1, 1, 1);
            step("R2", 1, 1, 1, 1, 1, 1, 1);
        end
        // R3 R4 R5 R6 R9: acknowledge sweep over hold length, wait pulse and read level
        for (int len = 1; len <= 8; len++) begin
            for (int wp = -1; wp < len; wp++) begin
                for (int rl = 0; rl < 2; rl++) begin
                    for (int c = 0; c < len; c++) begin
                        string tg;
                        if (c == wp)            tg = "R9";
                        else if (c == 0)        tg = "R3";
                        else if (c - 1 < TAP)   tg = "R5";
                        else                    tg = "R4";
                        step(tg, 1, 0, 1, (c == 0) ? 1'b1 : 1'b0, rl[0], 1'b1,
                             (c == wp) ? 1'b0 : 1'b1);
                    end
                    step("R6", 1, 1, 1, 1, 1, 1, 1);
                    step("R6", 1, 1, 1, 1, 1, 1, 1);
                end
            end
        end
        // R7: reset in the middle of an acknowledge, then a clean acknowledge
        step("R3", 1, 0, 1, 1, 1, 1, 1);
        step("R5", 1, 0, 1, 0, 1, 1, 1);
        step("R7", 0, 0, 1, 0, 1, 1, 1);
        step("R7", 0, 1, 1, 1, 1, 1, 1);
        step("R6", 1, 1, 1, 1, 1, 1, 1);
        for (int c = 0; c < TAP + 2; c++) step("R4", 1, 0, 1, (c == 0) ? 1'b1 : 1'b0, 1, 1, 1);
        step("R6", 1, 1, 1, 1, 1, 1, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule